// File: doc/BRIEF.md
# Bus Transmit Guard for a High-Speed CAN Transceiver

This block is the digital control core that sits between a CAN protocol controller and the analog line driver of a high-speed transceiver. It takes the controller's transmit line (low requests a dominant bit), a listen-only select, an enable, an over-temperature flag from the sensor and the bus-dominant flag from the receive comparator. From these it produces the enable of the dominant driver, the receive data returned to the controller and an enable for that receive output.

Three operating modes are decoded: active, where the driver follows the transmit line; listen-only, where the driver is held off but reception continues; and off, where both the driver and the receive output are disabled. Two protections can override the driver. A dominant watchdog starts on each falling transmit edge and cuts the driver if the line stays low too long. A thermal latch cuts the driver while the chip is hot and releases only once the chip has cooled and the transmit line is high. The control inputs pass through reset-initialised synchronizers. Their reset values are the safe levels an unconnected pin would take: transmit high, listen-only low, enable low.

Top module: `can_tx_guard`

## Requirements
- R1: In active mode (enable high, listen-only low), `drive_o` is the inverse of `txd_n_i`, and a change on `txd_n_i` reaches `drive_o` at the third rising clock edge after it.
- R2: In listen-only mode (`listen_i` high, enable high), `drive_o` stays 0 for either level of `txd_n_i`, and `rxd_oe_o` is 1.
- R3: In off mode (`enable_i` low), `drive_o` and `rxd_oe_o` are both 0 whatever the other inputs are. In every other mode `rxd_oe_o` is 1.
- R4: `rxd_o` is 0 while `bus_dom_i` is 1 and 1 while it is 0, with no clock delay. This holds in every mode where `rxd_oe_o` is 1, and so also when another node drives the bus during listen-only mode.
- R5: After a falling edge on `txd_n_i` in active mode, with no other fault present, `drive_o` is 1 for exactly `DOM_LIMIT` clock cycles and then falls to 0 while `txd_n_i` stays low.
- R6: After a watchdog timeout, `drive_o` stays 0 for as long as `txd_n_i` stays low. Only a rising edge on `txd_n_i` re-arms the driver, so that the next low drives again.
- R7: A low pulse shorter than `DOM_LIMIT` cycles never trips the watchdog. The count restarts at every falling edge, so a train of short lows whose total exceeds the limit is passed through whole.
- R8: While `hot_i` is 1, `drive_o` is 0 within four clock edges and stays 0. Reception (`rxd_o`, `rxd_oe_o`) is unaffected.
- R9: The thermal cut-off clears only once `hot_i` is 0 and `txd_n_i` is high. If `hot_i` falls while `txd_n_i` is still low, the driver stays off until `txd_n_i` has gone high.
- R10: A synchronous reset (`rst_i` high) clears all state. The synchronizers take the safe levels: transmit high, listen-only low, enable low. `drive_o` is 0, and the driver stays disabled until the first rising edge of `txd_n_i` after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| txd_n_i | input | 1 | Transmit data from the controller; 0 requests dominant |
| listen_i | input | 1 | Listen-only select; 1 holds the driver off |
| enable_i | input | 1 | Transceiver enable; 0 selects off mode |
| hot_i | input | 1 | Over-temperature flag from the sensor |
| bus_dom_i | input | 1 | Receive comparator output; 1 means the bus is dominant |
| drive_o | output | 1 | Dominant driver enable |
| rxd_o | output | 1 | Receive data to the controller; 0 means dominant |
| rxd_oe_o | output | 1 | Output enable for `rxd_o`; 0 floats the receive pin |

## Verification
A watchdog counter that is off by one shows directly as the length of the dominant window, so the bench counts `drive_o` cycles for every pulse length across the limit and compares the count with the smaller of the pulse length and `DOM_LIMIT`. A timeout latch that clears wrongly appears as `drive_o` rising again while the line is still low, within one cycle of the bad clear. Thermal and mode errors appear as a driven bus in a state that forbids it, and the bench samples these a few edges after each input change. A wrong reset value shows up in the first samples after reset as an enabled receive output or a driver that is live without a prior rising edge.

// File: rtl/can_tx_guard_pkg.sv
`timescale 1ns/1ps
package can_tx_guard_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_LISTEN = 2'd1,
      MODE_ACTIVE = 2'd2
   } bus_mode_e;

   // Enable low wins over everything; listen-only wins over transmit.
   function automatic bus_mode_e decode_mode(input logic enable, input logic listen);
      if (!enable)
         return MODE_OFF;
      else if (listen)
         return MODE_LISTEN;
      else
         return MODE_ACTIVE;
   endfunction

   // Bit positions inside the synchronizer bank.
   localparam int unsigned SYN_TXD    = 0;
   localparam int unsigned SYN_LISTEN = 1;
   localparam int unsigned SYN_ENABLE = 2;
   localparam int unsigned SYN_HOT    = 3;
   localparam int unsigned SYN_WIDTH  = 4;

endpackage

// File: rtl/ctg_sync_bank.sv
`timescale 1ns/1ps
module ctg_sync_bank #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ctg_sync_bank: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ctg_sync_bank: WIDTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stage_q <= {DEPTH{RST_VAL}};
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < DEPTH; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[LAST];

endmodule

// File: rtl/ctg_dom_watchdog.sv
`timescale 1ns/1ps
module ctg_dom_watchdog #(
   parameter int unsigned DOM_LIMIT = 625000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic txd_i,      // synchronized transmit level, 0 = dominant request
   output logic block_o     // 1 while the driver must stay off
);

   localparam int unsigned CW = $clog2(DOM_LIMIT + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(DOM_LIMIT - 1);

   generate
      if (DOM_LIMIT < 2) begin : g_bad_limit
         $error("ctg_dom_watchdog: DOM_LIMIT must be at least 2");
      end
   endgenerate

   logic          txd_q;
   logic          run_q;
   logic          block_q;
   logic [CW-1:0] cnt_q;
   logic          rise;
   logic          fall;

   assign rise = txd_i & ~txd_q;
   assign fall = ~txd_i & txd_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         txd_q   <= 1'b1;
         run_q   <= 1'b0;
         cnt_q   <= '0;
         block_q <= 1'b1;          // armed only by the first rising edge
      end else begin
         txd_q <= txd_i;
         if (rise) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            block_q <= 1'b0;
         end else if (fall) begin
            run_q <= 1'b1;
            cnt_q <= CW'(1);
         end else if (run_q) begin
            if (cnt_q == LAST_CNT) begin
               run_q   <= 1'b0;
               block_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   assign block_o = block_q;

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      run_q |-> (cnt_q <= LAST_CNT)); // R5
   AST_BLOCK_HOLD_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (block_q && !txd_i) |=> block_q); // R6
   AST_RISE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      rise |=> !block_q); // R6

endmodule

// File: rtl/ctg_thermal_latch.sv
`timescale 1ns/1ps
module ctg_thermal_latch (
   input  logic clk_i,
   input  logic rst_i,
   input  logic hot_i,      // synchronized over-temperature flag
   input  logic txd_i,      // synchronized transmit level
   output logic cut_o
);

   logic cut_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cut_q <= 1'b0;
      end else if (hot_i) begin
         cut_q <= 1'b1;
      end else if (txd_i) begin
         cut_q <= 1'b0;
      end
   end

   assign cut_o = cut_q;

   AST_HOT_SETS_CUT: assert property (@(posedge clk_i) disable iff (rst_i)
      hot_i |=> cut_q); // R8
   AST_CUT_HOLD_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (cut_q && !txd_i) |=> cut_q); // R9

endmodule

// File: rtl/can_tx_guard.sv
`timescale 1ns/1ps
module can_tx_guard
   import can_tx_guard_pkg::*;
#(
   parameter int unsigned DOM_LIMIT  = 625000,  // 2.5 ms at 250 MHz
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic txd_n_i,
   input  logic listen_i,
   input  logic enable_i,
   input  logic hot_i,
   input  logic bus_dom_i,
   output logic drive_o,
   output logic rxd_o,
   output logic rxd_oe_o
);

   // Safe levels of floating pins: transmit high, listen-only and enable low.
   localparam logic [SYN_WIDTH-1:0] SAFE_LEVELS = SYN_WIDTH'(1) << SYN_TXD;

   logic [SYN_WIDTH-1:0] raw;
   logic [SYN_WIDTH-1:0] syn;
   logic                 dog_block;
   logic                 heat_cut;
   logic                 drive_q;
   bus_mode_e            mode;

   always_comb begin
      raw             = '0;
      raw[SYN_TXD]    = txd_n_i;
      raw[SYN_LISTEN] = listen_i;
      raw[SYN_ENABLE] = enable_i;
      raw[SYN_HOT]    = hot_i;
   end

   ctg_sync_bank #(
      .WIDTH   (SYN_WIDTH),
      .DEPTH   (SYNC_DEPTH),
      .RST_VAL (SAFE_LEVELS)
   ) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (raw),
      .q_o   (syn)
   );

   ctg_dom_watchdog #(
      .DOM_LIMIT (DOM_LIMIT)
   ) u_dog (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .txd_i   (syn[SYN_TXD]),
      .block_o (dog_block)
   );

   ctg_thermal_latch u_heat (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .hot_i (syn[SYN_HOT]),
      .txd_i (syn[SYN_TXD]),
      .cut_o (heat_cut)
   );

   assign mode = decode_mode(syn[SYN_ENABLE], syn[SYN_LISTEN]);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         drive_q <= 1'b0;
      end else begin
         drive_q <= (mode == MODE_ACTIVE) && !syn[SYN_TXD] && !dog_block && !heat_cut;
      end
   end

   assign drive_o  = drive_q;
   assign rxd_oe_o = (mode != MODE_OFF);
   assign rxd_o    = ~bus_dom_i;

   AST_QUIET_MODES: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode != MODE_ACTIVE) |=> !drive_o); // R2
   AST_OFF_NO_RX: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode == MODE_OFF) |-> !rxd_oe_o); // R3
   AST_DOG_CUTS: assert property (@(posedge clk_i) disable iff (rst_i)
      dog_block |=> !drive_o); // R5
   AST_HEAT_CUTS: assert property (@(posedge clk_i) disable iff (rst_i)
      heat_cut |=> !drive_o); // R8
   AST_RECESSIVE_TXD: assert property (@(posedge clk_i) disable iff (rst_i)
      syn[SYN_TXD] |=> !drive_o); // R1

endmodule

// File: tb/tb_can_tx_guard.sv
`timescale 1ns/1ps
module tb_can_tx_guard;

   localparam int unsigned LIM = 40;

   logic clk = 1'b0;
   logic rst;
   logic txd_n, listen, enable, hot, bus_dom;
   logic drive, rxd, rxd_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   can_tx_guard #(.DOM_LIMIT(LIM), .SYNC_DEPTH(2)) dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .txd_n_i   (txd_n),
      .listen_i  (listen),
      .enable_i  (enable),
      .hot_i     (hot),
      .bus_dom_i (bus_dom),
      .drive_o   (drive),
      .rxd_o     (rxd),
      .rxd_oe_o  (rxd_oe)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_n(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic count_high(input int n, inout int acc);
      for (int i = 0; i < n; i++) begin
         step(1);
         if (drive === 1'b1) acc++;
      end
   endtask

   task automatic rearm();
      txd_n = 1'b1;
      step(8);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; txd_n = 1'b1; listen = 1'b0; enable = 1'b0; hot = 1'b0; bus_dom = 1'b0;
      step(3);
      rst = 1'b0;
      // R10: reset state
      check("R10 drive after reset", drive, 1'b0);
      check("R10 rxd_oe after reset", rxd_oe, 1'b0);
      // R10: no drive before the first rising edge
      enable = 1'b1; txd_n = 1'b0;
      step(10);
      check("R10 locked until first rise", drive, 1'b0);
      check("R3 oe in active mode", rxd_oe, 1'b1);

      // R1: latency of exactly three edges
      rearm();
      txd_n = 1'b0;
      step(2); check("R1 before third edge (fall)", drive, 1'b0);
      step(1); check("R1 at third edge (fall)", drive, 1'b1);
      txd_n = 1'b1;
      step(2); check("R1 before third edge (rise)", drive, 1'b1);
      step(1); check("R1 at third edge (rise)", drive, 1'b0);

      // Mode sweep: R1, R2, R3, R4
      for (int q = 0; q < 2; q++) begin
         for (int e = 0; e < 2; e++) begin
            for (int t = 0; t < 2; t++) begin
               listen = 1'b0; enable = 1'b1;
               rearm();
               listen = q[0]; enable = e[0]; txd_n = t[0];
               step(8);
               if (e == 0) begin
                  check("R3 off mode drive", drive, 1'b0);
                  check("R3 off mode oe", rxd_oe, 1'b0);
               end else if (q == 1) begin
                  check("R2 listen drive", drive, 1'b0);
                  check("R2 listen oe", rxd_oe, 1'b1);
               end else begin
                  check("R1 active drive", drive, ~t[0]);
               end
               for (int b = 0; b < 2; b++) begin
                  bus_dom = b[0];
                  #1;
                  if (e == 1) check("R4 rxd follows bus", rxd, ~b[0]);
               end
               bus_dom = 1'b0;
            end
         end
      end
      listen = 1'b0; enable = 1'b1;

      // Pulse length sweep: R5 and R7
      for (int len = 1; len <= int'(LIM) + 4; len++) begin
         int hi;
         hi = 0;
         rearm();
         txd_n = 1'b0;
         count_high(len, hi);
         txd_n = 1'b1;
         count_high(10, hi);
         if (len >= int'(LIM))
            check_n($sformatf("R5 window for low of %0d", len), hi, int'(LIM));
         else
            check_n($sformatf("R7 short low of %0d", len), hi, len);
      end

      // R6: stays off while low, re-armed by a rising edge
      rearm();
      txd_n = 1'b0;
      step(LIM + 10);
      check("R6 off after timeout", drive, 1'b0);
      step(20);
      check("R6 still off while low", drive, 1'b0);
      txd_n = 1'b1;
      step(8);
      check("R6 recessive after rise", drive, 1'b0);
      txd_n = 1'b0;
      step(4);
      check("R6 drives after re-arm", drive, 1'b1);

      // R7: train of short lows with one-cycle gaps
      begin
         int hi;
         hi = 0;
         rearm();
         for (int k = 0; k < 4; k++) begin
            txd_n = 1'b0;
            count_high(LIM - 2, hi);
            txd_n = 1'b1;
            count_high(1, hi);
         end
         count_high(10, hi);
         check_n("R7 timer restarts per fall", hi, 4 * (int'(LIM) - 2));
      end

      // R8 and R9: hot while transmitting
      rearm();
      txd_n = 1'b0;
      step(4);
      check("R8 driving before hot", drive, 1'b1);
      hot = 1'b1;
      step(6);
      check("R8 hot cuts driver", drive, 1'b0);
      bus_dom = 1'b1;
      #1;
      check("R8 rxd works while hot", rxd, 1'b0);
      check("R8 oe while hot", rxd_oe, 1'b1);
      bus_dom = 1'b0;
      hot = 1'b0;
      step(6);
      check("R9 cool but txd low stays off", drive, 1'b0);
      txd_n = 1'b1;
      step(6);
      txd_n = 1'b0;
      step(4);
      check("R9 released after cool and high", drive, 1'b1);

      // R8 and R9: hot while recessive
      rearm();
      hot = 1'b1;
      step(6);
      txd_n = 1'b0;
      step(6);
      check("R8 hot blocks new frame", drive, 1'b0);
      txd_n = 1'b1;
      step(4);
      txd_n = 1'b0;
      step(6);
      check("R9 high while hot does not release", drive, 1'b0);
      txd_n = 1'b1;
      hot = 1'b0;
      step(6);
      txd_n = 1'b0;
      step(4);
      check("R9 release after cool", drive, 1'b1);

      // R10: reset in the middle of a dominant bit
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      step(1);
      check("R10 drive off after mid-frame reset", drive, 1'b0);
      check("R10 oe off right after reset", rxd_oe, 1'b0);
      step(10);
      check("R10 held off without rising edge", drive, 1'b0);
      txd_n = 1'b1;
      step(6);
      txd_n = 1'b0;
      step(4);
      check("R10 drives after first rise", drive, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule